// File: doc/BRIEF.md
# Synchronous Bus Master with Wait States

This block is the master side of a synchronous memory bus on which every transfer lasts a whole number of bus clock cycles. A local client gives it one read or write at a time. Each request carries an address, write data and a direction flag. The master then runs the transfer on the bus. For the whole transfer it drives an active-low memory request strobe, an active-low read strobe and the address lines. For writes it also drives the data lines, qualified by an output-enable flag.

A transfer is never shorter than a fixed minimum number of cycles, set by a parameter. Once that minimum has been reached, a slave can hold the active-low wait line low to add whole extra cycles. The transfer ends at the close of the first cycle at or after the minimum in which the wait line is high. On a read, the bus data present at that edge is captured. In the following cycle the master returns the captured data together with a one-cycle done pulse.

Top module: `bus_master_sync`

## Requirements
- R1: After reset, `bus_mreq_n` and `bus_rd_n` are 1, `bus_doe` is 0, `done` is 0 and `req_ready` is 1.
- R2: A request is taken only while `req_ready` is 1. A `req_valid` pulse during a transfer leaves the bus address unchanged and starts no extra transfer.
- R3: `bus_mreq_n` is 0 in every cycle of a transfer. With the wait line high, a transfer lasts exactly MIN_CYCLES cycles.
- R4: `bus_rd_n` is 0 in every cycle of a read transfer and stays 1 throughout a write transfer.
- R5: `bus_addr` equals the request address from the first cycle of the transfer through its last cycle.
- R6: Each cycle at or after cycle MIN_CYCLES in which `bus_wait_n` is 0 adds exactly one cycle to the transfer.
- R7: `bus_wait_n` = 0 in a cycle before cycle MIN_CYCLES has no effect on the transfer length.
- R8: On a read, `rdata` in the cycle after the final cycle equals the `bus_din` value present at the end of the final cycle.
- R9: During a write, `bus_doe` is 1 and `bus_dout` equals the write data from cycle 2 through the last cycle. `bus_doe` is 0 in cycle 1, during reads and when no transfer is running.
- R10: `done` is 1 for exactly one cycle, the cycle right after the final transfer cycle, and `bus_mreq_n` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_ready | output | 1 | Master idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Data captured by the last read |
| bus_mreq_n | output | 1 | Active-low memory request strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_addr | output | ADDR_W | Bus address lines |
| bus_dout | output | DATA_W | Bus write data |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DATA_W | Bus read data from the slave |
| bus_wait_n | input | 1 | Active-low wait request from the slave |

## Verification
The bench builds the block with MIN_CYCLES = 3 and 16-bit address and data. At that minimum, every region of a transfer can be reached in a short run: the first cycle without write data, a middle cycle in which a low wait line must be ignored, and the decision cycle in which wait states begin. Random transfers mix directions, early wait pulses, up to three stretch cycles and requests raised while busy. Between final cycles, `bus_din` carries random values, so capturing at the wrong edge is exposed.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic {
        SBM_IDLE = 1'b0,
        SBM_XFER = 1'b1
    } sbm_state_e;

endpackage

// File: rtl/sbm_cycle_timer.sv
module sbm_cycle_timer #(
    parameter int MIN_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic at_min,
    output logic first_cycle
);
    localparam int CNT_W = $clog2(MIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_CYCLES);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_ONE;
        end else if (run) begin
            if (cnt_q < CNT_MIN) begin
                cnt_d = cnt_q + CNT_ONE;
            end
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_min      = (cnt_q >= CNT_MIN);
    assign first_cycle = (cnt_q == CNT_ONE);

    // Counter saturates at the minimum and never exceeds it (R3)
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MIN);

    // While running below the minimum the count advances by one (R3)
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && cnt_q < CNT_MIN) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

endmodule

// File: rtl/sbm_read_capture.sv
module sbm_read_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (capture) begin
            data_d = bus_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign rdata = data_q;

    // Returned data only changes on a capture edge (R8)
    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(data_q));

    // A capture edge loads the bus value (R8)
    assert_rdata_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (data_q == $past(bus_din)));

endmodule

// File: rtl/bus_master_sync.sv
module bus_master_sync
    import sbm_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int MIN_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_mreq_n,
    output logic              bus_rd_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_wait_n
);

    typedef struct packed {
        sbm_state_e        state;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
    } sbm_regs_t;

    sbm_regs_t r_d, r_q;

    logic start;
    logic xfer;
    logic at_min;
    logic first_cycle;
    logic final_cycle;
    logic capture;

    initial begin
        assert (MIN_CYCLES >= 2)
            else $error("MIN_CYCLES must be at least 2");
    end

    assign xfer        = (r_q.state == SBM_XFER);
    assign start       = (r_q.state == SBM_IDLE) && req_valid;
    assign final_cycle = xfer && at_min && bus_wait_n;
    assign capture     = final_cycle && !r_q.write;

    sbm_cycle_timer #(
        .MIN_CYCLES(MIN_CYCLES)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .run        (xfer),
        .at_min     (at_min),
        .first_cycle(first_cycle)
    );

    sbm_read_capture #(
        .DATA_W(DATA_W)
    ) i_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .bus_din(bus_din),
        .rdata  (rdata)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            SBM_IDLE: begin
                if (req_valid) begin
                    r_d.state = SBM_XFER;
                    r_d.write = req_write;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                end
            end
            SBM_XFER: begin
                if (at_min && bus_wait_n) begin
                    r_d.state = SBM_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = SBM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SBM_IDLE, write: 1'b0, addr: '0, wdata: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.state == SBM_IDLE);
    assign done       = r_q.done;
    assign bus_mreq_n = !xfer;
    assign bus_rd_n   = !(xfer && !r_q.write);
    assign bus_addr   = xfer ? r_q.addr : '0;
    assign bus_doe    = xfer && r_q.write && !first_cycle;
    assign bus_dout   = bus_doe ? r_q.wdata : '0;

    // Strobes released and data lines off while idle (R1)
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_mreq_n && bus_rd_n && !bus_doe));

    // Transfer cannot end before the minimum count (R3)
    assert_min_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mreq_n && !at_min) |=> !bus_mreq_n);

    // Write transfers keep the read strobe negated (R4)
    assert_write_no_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mreq_n && r_q.write) |-> bus_rd_n);

    // Address stable across consecutive transfer cycles (R5)
    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mreq_n && !$past(bus_mreq_n)) |-> $stable(bus_addr));

    // Low wait line at or after the minimum adds a cycle (R6)
    assert_wait_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mreq_n && at_min && !bus_wait_n) |=> !bus_mreq_n);

    // Write data only driven while a write transfer runs (R9)
    assert_doe_in_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (!bus_mreq_n && bus_rd_n));

    // Done lasts one cycle and follows a transfer cycle (R10)
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_mreq_n && !$past(bus_mreq_n)));

endmodule

// File: tb/test_bus_master_sync.sv
module test_bus_master_sync;

    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int MIN = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          done;
    logic [DW-1:0] rdata;
    logic          bus_mreq_n;
    logic          bus_rd_n;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout;
    logic          bus_doe;
    logic [DW-1:0] bus_din = '0;
    logic          bus_wait_n = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_master_sync #(
        .ADDR_W(AW), .DATA_W(DW), .MIN_CYCLES(MIN)
    ) i_bus_master_sync (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .bus_mreq_n(bus_mreq_n), .bus_rd_n(bus_rd_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_wait_n(bus_wait_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_len(input int post_w);
        return MIN + post_w;
    endfunction

    function automatic bit exp_wait_low(input int k, input int pre_w, input int post_w);
        return (k < MIN && k <= pre_w) || (k >= MIN && (k - MIN) < post_w);
    endfunction

    // Caller is at a negative edge with the master idle
    task automatic run_xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                            input int pre_w, input int post_w, input bit poke);
        logic [DW-1:0] rv;
        int total;
        rv    = DW'($urandom);
        total = exp_len(post_w);
        chk(req_ready == 1'b1, "R2 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= total; k++) begin
            chk(bus_mreq_n == 1'b0, "R3 mreq low in transfer", 32'(bus_mreq_n), 32'd0);
            chk(bus_rd_n == wr, "R4 read strobe", 32'(bus_rd_n), 32'(wr));
            chk(bus_addr == a, "R5 address held", 32'(bus_addr), 32'(a));
            chk(bus_doe == (wr && k >= 2), "R9 data enable", 32'(bus_doe), 32'(wr && k >= 2));
            if (wr && k >= 2) begin
                chk(bus_dout == wd, "R9 write data", 32'(bus_dout), 32'(wd));
            end
            chk(done == 1'b0, "R10 no done during transfer", 32'(done), 32'd0);
            chk(req_ready == 1'b0, "R2 busy", 32'(req_ready), 32'd0);
            if (poke && k == 2) begin
                req_valid = 1'b1;
                req_addr  = ~a;
                req_write = ~wr;
            end else begin
                req_valid = 1'b0;
            end
            bus_wait_n = !exp_wait_low(k, pre_w, post_w);
            bus_din    = (k == total) ? rv : DW'($urandom);
            @(negedge clk);
        end
        req_valid  = 1'b0;
        bus_wait_n = 1'b1;
        bus_din    = DW'($urandom);
        chk(done == 1'b1, "R10 done pulse", 32'(done), 32'd1);
        chk(bus_mreq_n == 1'b1, "R6 transfer length", 32'(bus_mreq_n), 32'd1);
        chk(bus_doe == 1'b0, "R9 data released", 32'(bus_doe), 32'd0);
        if (!wr) begin
            chk(rdata == rv, "R8 read data", 32'(rdata), 32'(rv));
        end
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", 32'(done), 32'd0);
        chk(bus_mreq_n == 1'b1, "R2 no extra transfer", 32'(bus_mreq_n), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(bus_mreq_n == 1'b1, "R1 mreq in reset", 32'(bus_mreq_n), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_mreq_n == 1'b1, "R1 mreq after reset", 32'(bus_mreq_n), 32'd1);
        chk(bus_rd_n == 1'b1, "R1 rd after reset", 32'(bus_rd_n), 32'd1);
        chk(bus_doe == 1'b0, "R1 doe after reset", 32'(bus_doe), 32'd0);
        chk(done == 1'b0, "R1 done after reset", 32'(done), 32'd0);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);

        // Directed corners
        run_xfer(1'b0, 16'h1234, 16'h0000, 0, 0, 1'b0);   // R3 R8 plain read
        run_xfer(1'b1, 16'hBEEF, 16'hA5C3, 0, 0, 1'b0);   // R9 plain write
        run_xfer(1'b0, 16'h0042, 16'h0000, 0, 3, 1'b0);   // R6 three stretch cycles
        run_xfer(1'b1, 16'h7777, 16'h5A5A, 2, 0, 1'b0);   // R7 early wait ignored
        run_xfer(1'b0, 16'h00FF, 16'h0000, 2, 1, 1'b1);   // R2 R7 R6 poke while busy
        run_xfer(1'b1, 16'hFFFF, 16'hFFFF, 0, 1, 1'b1);   // R2 write with poke

        for (int i = 0; i < 40; i++) begin
            run_xfer(1'($urandom), AW'($urandom), DW'($urandom),
                     int'($urandom % 3), int'($urandom % 4), ($urandom % 4) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule